// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block sits at the front of a Reed-Solomon decoder over GF(2^8). Received code symbols arrive one byte per accepted beat. For every syndrome index i it keeps a running evaluation of the received polynomial at alpha^i, with alpha = 0x02 and field polynomial x^8+x^4+x^3+x^2+1 (0x11D). The evaluation uses Horner's rule, so each accepted byte costs one constant multiply and one XOR per syndrome. When the 255th byte of a block is accepted, the block publishes all syndromes side by side. It also raises a flag that is set when at least one syndrome is non-zero. Downstream logic uses that flag to skip correction on clean blocks.

The parameter `N_SYN` sets how many syndromes are formed. It is 16 for the code with t=8 (239 data bytes) and 12 for the code with t=6 (243 data bytes). The input is a valid/ready stream. `in_ready` is high in every cycle outside reset, so the block never applies back-pressure. A beat transfers exactly when `in_valid` and `in_ready` are both high. The sender may drop `in_valid` at any time, and idle cycles only stretch the block. A new block may start on the beat right after the last byte of the previous one.

Top module: `rs_syndrome_calc`

## Requirements
- R1: Byte number k of a block (k = 0..254, counted in transfer order) is the coefficient of x^(254-k). After the block, field `syn_vec[8*i+7:8*i]` equals the received polynomial evaluated at alpha^i in GF(2^8) with polynomial 0x11D and alpha = 0x02.
- R2: `N_SYN` of 16 gives syndromes for i = 0..15, and `N_SYN` of 12 gives i = 0..11. With the same input stream, both widths give identical values for the shared indices.
- R3: `syn_done` is high for exactly one cycle, in the cycle after the 255th transferred byte of a block, and it is never high at any other time.
- R4: `syn_err` is 1 exactly when some field of `syn_vec` is non-zero. A valid codeword gives all fields 0 and `syn_err` 0.
- R5: `syn_vec` and `syn_err` change only in the cycle in which `syn_done` is high, and hold their values between pulses.
- R6: A cycle with `in_valid` low transfers nothing. The value on `in_sym` in that cycle has no effect on any result.
- R7: Blocks may follow one another with no gap. The first byte of the next block may transfer in the cycle in which `syn_done` reports the previous block. Pulses from gap-free blocks are then exactly 255 cycles apart.
- R8: `in_ready` is 0 while `rst` is high and 1 otherwise.
- R9: Synchronous reset discards any partial block and returns the symbol position to the start of a block. It also drives `syn_done` and `syn_err` to 0 and every field of `syn_vec` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts a byte (high outside reset) |
| in_sym | input | 8 | Received byte, highest-power coefficient first |
| syn_done | output | 1 | One-cycle strobe: new syndromes available |
| syn_vec | output | 8*N_SYN | Syndrome i in bits 8*i+7 .. 8*i |
| syn_err | output | 1 | Some syndrome is non-zero |

## Verification
Two events can fall in the same cycle. In one cycle the final byte of a block completes the syndromes and they are captured for output. At that same clock edge the first byte of the next block reloads the accumulators. The bench provokes this by streaming several encoded blocks with `in_valid` held high across block boundaries. It judges the outcome by comparing each published vector with a reference evaluation of that exact block. It also checks that the strobes of consecutive blocks are exactly 255 cycles apart. Corrupted first or last bytes show up as mismatches in either the finishing block or the one that follows.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  localparam int SYM_W = 8;

  // Shift-and-add product in GF(2^8); poly carries the x^8 term in bit 8.
  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b,
                                              input logic [SYM_W:0]   poly);
    logic [SYM_W-1:0] prod;
    logic [SYM_W-1:0] run;
    prod = '0;
    run  = a;
    for (int k = 0; k < SYM_W; k++) begin
      if (b[k]) prod = prod ^ run;
      run = run[SYM_W-1] ? ((run << 1) ^ poly[SYM_W-1:0]) : (run << 1);
    end
    return prod;
  endfunction

  // alpha^e with alpha = 2.
  function automatic logic [SYM_W-1:0] alpha_pow(input int e,
                                                 input logic [SYM_W:0] poly);
    logic [SYM_W-1:0] r;
    r = 8'h01;
    for (int k = 0; k < e; k++) r = gf_mul(r, 8'h02, poly);
    return r;
  endfunction

endpackage

// File: rtl/rs_syn_pos.sv
module rs_syn_pos #(
  parameter int N_SYMS = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic first,
  output logic last
);
  localparam int POS_W = $clog2(N_SYMS);
  localparam logic [POS_W-1:0] POS_END = POS_W'(N_SYMS - 1);

  logic [POS_W-1:0] pos;

  assign first = (pos == '0);
  assign last  = (pos == POS_END);

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (fire) pos <= last ? '0 : pos + 1'b1;
  end

  // R1: position stays inside the block
  a_r1_pos_bound: assert property (@(posedge clk) disable iff (rst)
    pos <= POS_END);

  // R7: after the final byte the next beat is a block start
  a_r7_wrap_to_start: assert property (@(posedge clk) disable iff (rst)
    (fire && last) |=> first);

endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_syn_pkg::*;
#(
  parameter int         POWER      = 1,
  parameter logic [8:0] FIELD_POLY = 9'h11D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             first,
  input  logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] acc_nxt
);
  localparam logic [SYM_W-1:0] ROOT = alpha_pow(POWER, FIELD_POLY);

  logic [SYM_W-1:0] acc;

  // Horner step; the first byte of a block replaces the old sum.
  assign acc_nxt = first ? sym : (gf_mul(acc, ROOT, FIELD_POLY) ^ sym);

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (fire) acc <= acc_nxt;
  end

  // R6: no transfer, no change
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(acc));

  // R7: a block start loads the incoming byte alone
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    (fire && first) |=> (acc == $past(sym)));

endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc
  import rs_syn_pkg::*;
#(
  parameter int         N_SYN      = 16,
  parameter int         N_SYMS     = 255,
  parameter logic [8:0] FIELD_POLY = 9'h11D
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SYM_W-1:0]       in_sym,
  output logic                   syn_done,
  output logic [N_SYN*SYM_W-1:0] syn_vec,
  output logic                   syn_err
);
  localparam int VEC_W = N_SYN * SYM_W;

  logic             fire;
  logic             first;
  logic             last;
  logic [VEC_W-1:0] nxt_flat;

  assign in_ready = !rst;
  assign fire     = in_valid && in_ready;

  rs_syn_pos #(.N_SYMS(N_SYMS)) u_pos (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .first (first),
    .last  (last)
  );

  for (genvar i = 0; i < N_SYN; i++) begin : g_cell
    rs_syn_cell #(.POWER(i), .FIELD_POLY(FIELD_POLY)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .fire    (fire),
      .first   (first),
      .sym     (in_sym),
      .acc_nxt (nxt_flat[i*SYM_W +: SYM_W])
    );
  end

  // Capture the completed sums on the final beat so the accumulators are
  // free for the next block on the following beat.
  always_ff @(posedge clk) begin
    if (rst) begin
      syn_done <= 1'b0;
      syn_vec  <= '0;
      syn_err  <= 1'b0;
    end else begin
      syn_done <= fire && last;
      if (fire && last) begin
        syn_vec <= nxt_flat;
        syn_err <= |nxt_flat;
      end
    end
  end

  // R3: last beat is followed by the strobe
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (fire && last) |=> syn_done);

  // R3: no strobe without a completed block
  a_r3_no_stray_done: assert property (@(posedge clk) disable iff (rst)
    syn_done |-> $past(fire && last));

  // R4: flag agrees with the published vector
  a_r4_flag_matches: assert property (@(posedge clk) disable iff (rst)
    syn_done |-> (syn_err == (syn_vec != '0)));

  // R5: results hold between strobes
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !syn_done |-> ($stable(syn_vec) && $stable(syn_err)));

endmodule

// File: tb/rs_syndrome_calc_test.sv
module rs_syndrome_calc_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   in_sym = 8'h00;
  logic         in_ready, in_ready12;
  logic         done, done12;
  logic [127:0] syn;
  logic [95:0]  syn12;
  logic         err, err12;

  always #4 clk = ~clk;

  rs_syndrome_calc #(.N_SYN(16)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .syn_done(done), .syn_vec(syn), .syn_err(err));

  rs_syndrome_calc #(.N_SYN(12)) uut12 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready12),
    .in_sym(in_sym), .syn_done(done12), .syn_vec(syn12), .syn_err(err12));

  // seed, error count, gap mode
  localparam logic [39:0] VEC [6] = '{
    {32'h1234_5678, 4'd0, 4'd0},
    {32'h0BAD_F00D, 4'd1, 4'd0},
    {32'hCAFE_0003, 4'd3, 4'd0},
    {32'h7777_1111, 4'd6, 4'd1},
    {32'h3141_5926, 4'd8, 4'd0},
    {32'h2718_2818, 4'd8, 4'd1}
  };

  int n_chk = 0, n_fail = 0;
  int gexp [0:254];
  int glog [0:255];
  logic [7:0]   gpoly [0:16];
  logic [7:0]   rx [0:254];
  logic [31:0]  rng;
  logic [127:0] exp_syn [0:31];
  bit           exp_clean [0:31];
  int           n_issued = 0, n_sent = 0, done_seen = 0, hold_viol = 0;
  longint       cyc = 0;
  longint       done_cyc [0:31];
  logic [127:0] last_syn = '0;

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return 8'(gexp[(glog[a] + glog[b]) % 255]);
  endfunction

  task automatic init_field();
    int v = 1;
    for (int e = 0; e < 255; e++) begin
      gexp[e] = v; glog[v] = e;
      v = v << 1;
      if (v & 256) v = v ^ 'h11D;
    end
    for (int k = 0; k < 17; k++) gpoly[k] = 8'h00;
    gpoly[0] = 8'h01;
    for (int r = 0; r < 16; r++) begin
      for (int k = 16; k > 0; k--)
        gpoly[k] = gpoly[k-1] ^ fmul(gpoly[k], 8'(gexp[r]));
      gpoly[0] = fmul(gpoly[0], 8'(gexp[r]));
    end
  endtask

  // Codeword m(x)*g(x), then nerr distinct corrupted positions.
  task automatic build_block(input logic [31:0] seed, input int nerr);
    logic [7:0] msg [0:238];
    bit used [0:254];
    int placed = 0;
    rng = (seed == 0) ? 32'h1 : seed;
    for (int a = 0; a < 239; a++) msg[a] = rnd()[7:0];
    for (int p = 0; p < 255; p++) begin rx[p] = 8'h00; used[p] = 0; end
    for (int a = 0; a < 239; a++)
      for (int b = 0; b < 17; b++)
        rx[a+b] = rx[a+b] ^ fmul(msg[a], gpoly[b]);
    while (placed < nerr) begin
      int p = int'(rnd() % 255);
      if (!used[p]) begin
        used[p] = 1;
        rx[p] = rx[p] ^ 8'((rnd() % 255) + 1);
        placed++;
      end
    end
  endtask

  task automatic issue_expected(input bit clean);
    logic [127:0] e = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] s = 8'h00;
      for (int j = 0; j < 255; j++) s = s ^ fmul(rx[j], 8'(gexp[(i*j) % 255]));
      e[8*i +: 8] = s;
    end
    exp_syn[n_issued] = e;
    exp_clean[n_issued] = clean;
    n_issued++;
  endtask

  task automatic send(input int nsym, input bit gaps);
    for (int j = 0; j < nsym; j++) begin
      @(negedge clk);
      if (gaps) begin
        int idle = int'(rnd() % 3);
        for (int q = 0; q < idle; q++) begin
          in_valid = 1'b0; in_sym = 8'hA5 ^ 8'(q); // R6: junk while idle
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      in_sym = rx[254-j];
      @(posedge clk);
    end
    if (nsym == 255) n_sent++;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst) last_syn = '0;
    else if (done) begin
      chk(syn == exp_syn[done_seen], "R1 syndrome vector", syn, exp_syn[done_seen]);
      chk(err == (exp_syn[done_seen] != 0), "R4 error flag", 128'(err),
          128'(exp_syn[done_seen] != 0));
      if (exp_clean[done_seen])
        chk(syn == '0 && !err, "R4 valid codeword gives zero", syn, '0);
      chk(done12 && syn12 == exp_syn[done_seen][95:0] &&
          err12 == (exp_syn[done_seen][95:0] != 0),
          "R2 twelve-syndrome instance", 128'(syn12), 128'(exp_syn[done_seen][95:0]));
      chk(done_seen == n_sent - 1, "R3 strobe once per completed block",
          128'(done_seen), 128'(n_sent - 1));
      done_cyc[done_seen] = cyc;
      done_seen++;
      last_syn = syn;
    end else if (syn != last_syn || done12) hold_viol++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    init_field();
    repeat (3) @(negedge clk);
    chk(!in_ready && !in_ready12, "R8 ready low in reset", 128'(in_ready), 0);
    chk(!done && syn == '0 && !err, "R9 reset state", syn, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && in_ready12, "R8 ready high after reset", 128'(in_ready), 1);

    // Vector table; gap-free entries stream back to back (R7).
    for (int v = 0; v < 6; v++) begin
      build_block(VEC[v][39:8], int'(VEC[v][7:4]));
      issue_expected(VEC[v][7:4] == 0);
      send(255, VEC[v][3:0] != 0);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_cyc[1] - done_cyc[0] == 255, "R7 gap-free strobe spacing",
        128'(done_cyc[1] - done_cyc[0]), 255);

    // Only x^0 set: every syndrome is 1 (R1).
    for (int p = 0; p < 255; p++) rx[p] = 8'h00;
    rx[0] = 8'h01;
    issue_expected(0);
    send(255, 0);
    @(negedge clk); in_valid = 1'b0;
    chk(syn == {16{8'h01}}, "R1 unit coefficient at x^0", syn, {16{8'h01}});

    // All-zero block.
    rx[0] = 8'h00;
    issue_expected(1);
    send(255, 0);
    @(negedge clk); in_valid = 1'b0;

    // R5/R6: long idle with toggling data leaves results unchanged.
    begin
      logic [127:0] held = syn;
      for (int q = 0; q < 20; q++) begin in_sym = 8'(q * 37); @(negedge clk); end
      chk(syn == held && !done, "R5 results hold while idle", syn, held);
    end

    // R9: partial block discarded by reset.
    build_block(32'h5555_AAAA, 2);
    send(100, 0);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!in_ready, "R8 ready low in mid-run reset", 128'(in_ready), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!done && syn == '0 && !err, "R9 reset clears outputs", syn, '0);
    build_block(32'h0F0F_1234, 5);
    issue_expected(0);
    send(255, 1);
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);

    chk(done_seen == n_sent && n_sent == n_issued, "R3 strobe count",
        128'(done_seen), 128'(n_sent));
    chk(hold_viol == 0, "R5 no change between strobes", 128'(hold_viol), 0);
    summary();
  end

endmodule